// File: doc/BRIEF.md
# Per-Bank Refresh Timing Guard

This block sits beside a memory command scheduler and answers one question per cycle. Given a candidate command (row open, column read, column write or precharge), a target bank and the cycle the scheduler would like to issue it, it returns the earliest cycle at which that command may legally go out. The only constraint it covers is each bank's own upcoming refresh. If the command would run into the point where the bank must be forced closed ahead of its refresh, the command is deferred until that bank's refresh has completed.

For every bank the guard keeps two deadlines. One is the cycle of the bank's next per-bank refresh. The other is the cycle by which the bank must be precharged for that refresh. The deadlines of adjacent banks are staggered by one cycle. When the scheduler reports that a per-bank refresh was issued, the guard moves both deadlines of that bank forward by one refresh interval and stores the refresh start cycle. After that, a row open to the same bank cannot start until the refresh recovery time has elapsed. The answer is combinational, valid in the same cycle as the query. A recorded refresh changes the answers from the following cycle on.

All timing parameters are whole clock cycles, and all cycle values are absolute timestamps of width `TW`.

Top module: `refb_guard`

## Requirements
- R1: After reset, bank b's refresh deadline is T_REFI − (NUM_BANKS − 1) + b, and its precharge deadline is that value minus max(NUM_BANKS, T_RP).
- R2: A row open (qryCmd = 0) whose proposed cycle plus T_RAS is at or beyond the bank's precharge deadline is answered with the bank's refresh deadline plus T_RFC. An earlier one is answered with the proposed cycle.
- R3: A column read (qryCmd = 1) whose proposed cycle plus T_RTP is at or beyond the precharge deadline is answered with the refresh deadline plus T_RFC. Otherwise it is answered with the proposed cycle.
- R4: A column write (qryCmd = 2) whose proposed cycle plus T_WL + T_CCD + T_WR is at or beyond the precharge deadline is answered with the refresh deadline plus T_RFC. Otherwise it is answered with the proposed cycle.
- R5: A precharge (qryCmd = 3) is always answered with its proposed cycle.
- R6: A refresh recorded for bank b moves both of b's deadlines forward by T_REFI. The change is seen by queries from the next cycle on, while a query in the same cycle still sees the old deadlines. Other banks are unaffected.
- R7: Once a refresh to bank b has been recorded at cycle s, a row open to b is answered with at least s + T_RFC. Before the first refresh to a bank is recorded, no such bound applies to it.
- R8: The answer is never earlier than the proposed cycle. A proposed cycle already past a pushed-to value is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qryCmd | input | 2 | Candidate command: 0 row open, 1 read, 2 write, 3 precharge |
| qryBank | input | BANK_W | Target bank of the candidate |
| qryCycle | input | TW | Proposed issue cycle |
| insValid | input | 1 | A per-bank refresh was issued |
| insBank | input | BANK_W | Bank that was refreshed |
| insCycle | input | TW | Start cycle of that refresh |
| earliest | output | TW | Earliest legal issue cycle for the candidate |

## Verification
The hardest situation to reach is a query in the same cycle as a refresh record for the same bank, where the answer must still come from the old deadlines. One cycle later the same query must reflect both the advanced deadlines and the new recovery bound. The stimulus holds the record strobe high for one cycle, queries a read to that bank in that cycle, and then repeats the identical read in the next cycle. The two answers differ only if the update timing is correct. Row opens placed just below and just at the advanced threshold then separate the recovery bound from the refresh push.

// File: rtl/refb_guard_pkg.sv
package refb_guard_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selAct;
    logic selRd;
    logic selWr;
    logic bypass;
    logic record;
  } strobe_t;

endpackage

// File: rtl/refb_guard_ctrl.sv
module refb_guard_ctrl
  import refb_guard_pkg::*;
(
  input  logic [1:0] qryCmd,
  input  logic       insValid,
  output strobe_t    strb
);

  cmd_e cmdDec;

  always_comb begin
    cmdDec = cmd_e'(qryCmd);
    strb = '0;
    unique case (cmdDec)
      CMD_ACT: strb.selAct = 1'b1;
      CMD_RD:  strb.selRd  = 1'b1;
      CMD_WR:  strb.selWr  = 1'b1;
      default: strb.bypass = 1'b1;
    endcase
    strb.record = insValid;
  end

endmodule

// File: rtl/refb_guard_dp.sv
module refb_guard_dp
  import refb_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TW        = 32,
  parameter int T_REFI    = 1560,
  parameter int T_RP      = 6,
  parameter int T_RAS     = 15,
  parameter int T_RTP     = 4,
  parameter int T_WL      = 5,
  parameter int T_CCD     = 4,
  parameter int T_WR      = 6,
  parameter int T_RFC     = 44,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [BANK_W-1:0] qryBank,
  input  logic [TW-1:0]     qryCycle,
  input  logic [BANK_W-1:0] insBank,
  input  logic [TW-1:0]     insCycle,
  output logic [TW-1:0]     earliest
);

  localparam int PRE_GAP   = (NUM_BANKS > T_RP) ? NUM_BANKS : T_RP;
  localparam int INIT_REFB = T_REFI - (NUM_BANKS - 1);
  localparam int WR_MARGIN = T_WL + T_CCD + T_WR;

  logic [TW-1:0] nextRefb [NUM_BANKS];
  logic [TW-1:0] nextPre  [NUM_BANKS];
  logic [TW-1:0] lastRefb [NUM_BANKS];
  logic          lastValid[NUM_BANKS];

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = strb.record && (insBank == BANK_W'(b));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          nextRefb[b]  <= TW'(INIT_REFB + b);
          nextPre[b]   <= TW'(INIT_REFB + b - PRE_GAP);
          lastRefb[b]  <= '0;
          lastValid[b] <= 1'b0;
        end else if (hit) begin
          nextRefb[b]  <= nextRefb[b] + TW'(T_REFI);
          nextPre[b]   <= nextPre[b] + TW'(T_REFI);
          lastRefb[b]  <= insCycle;
          lastValid[b] <= 1'b1;
        end
      end
    end
  endgenerate

  logic [TW-1:0] selRefb, selPre, selLast, margin, pushed, cand, actBound;
  logic          selValid, crossing;

  always_comb begin
    selRefb  = nextRefb[qryBank];
    selPre   = nextPre[qryBank];
    selLast  = lastRefb[qryBank];
    selValid = lastValid[qryBank];

    if (strb.selAct)     margin = TW'(T_RAS);
    else if (strb.selRd) margin = TW'(T_RTP);
    else                 margin = TW'(WR_MARGIN);

    // compare in added form so no deadline subtraction can wrap
    crossing = !strb.bypass && ((qryCycle + margin) >= selPre);
    pushed   = selRefb + TW'(T_RFC);
    cand     = (crossing && (pushed > qryCycle)) ? pushed : qryCycle;

    actBound = (strb.selAct && selValid) ? (selLast + TW'(T_RFC)) : '0;
    earliest = (actBound > cand) ? actBound : cand;
  end

endmodule

// File: rtl/refb_guard.sv
module refb_guard
  import refb_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TW        = 32,
  parameter int T_REFI    = 1560,
  parameter int T_RP      = 6,
  parameter int T_RAS     = 15,
  parameter int T_RTP     = 4,
  parameter int T_WL      = 5,
  parameter int T_CCD     = 4,
  parameter int T_WR      = 6,
  parameter int T_RFC     = 44,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        qryCmd,
  input  logic [BANK_W-1:0] qryBank,
  input  logic [TW-1:0]     qryCycle,
  input  logic              insValid,
  input  logic [BANK_W-1:0] insBank,
  input  logic [TW-1:0]     insCycle,
  output logic [TW-1:0]     earliest
);

  strobe_t strb;

  refb_guard_ctrl ctrl_i (
    .qryCmd   (qryCmd),
    .insValid (insValid),
    .strb     (strb)
  );

  refb_guard_dp #(
    .NUM_BANKS (NUM_BANKS), .TW (TW), .T_REFI (T_REFI), .T_RP (T_RP),
    .T_RAS (T_RAS), .T_RTP (T_RTP), .T_WL (T_WL), .T_CCD (T_CCD),
    .T_WR (T_WR), .T_RFC (T_RFC)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .qryBank  (qryBank),
    .qryCycle (qryCycle),
    .insBank  (insBank),
    .insCycle (insCycle),
    .earliest (earliest)
  );

endmodule

// File: rtl/refb_guard_chk.sv
module refb_guard_chk #(
  parameter int TW     = 32,
  parameter int BANK_W = 3,
  parameter int T_RFC  = 44
)(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        qryCmd,
  input logic [BANK_W-1:0] qryBank,
  input logic [TW-1:0]     qryCycle,
  input logic              insValid,
  input logic [BANK_W-1:0] insBank,
  input logic [TW-1:0]     insCycle,
  input logic [TW-1:0]     earliest
);

  p_pre_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (qryCmd == 2'd3) |-> (earliest == qryCycle));

  p_never_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    earliest >= qryCycle);

  p_act_recovery_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(insValid) && (qryCmd == 2'd0) && (qryBank == $past(insBank)))
      |-> (earliest >= $past(insCycle) + TW'(T_RFC)));

  p_state_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(qryCmd) && $stable(qryBank) && $stable(qryCycle) && !$past(insValid))
      |-> $stable(earliest));

endmodule

bind refb_guard refb_guard_chk #(
  .TW (TW), .BANK_W (BANK_W), .T_RFC (T_RFC)
) chk_i (
  .clk (clk), .rst_n (rst_n), .qryCmd (qryCmd), .qryBank (qryBank),
  .qryCycle (qryCycle), .insValid (insValid), .insBank (insBank),
  .insCycle (insCycle), .earliest (earliest)
);

// File: tb/refb_guard_tb_top.sv
module refb_guard_tb_top;

  localparam int NB     = 8;
  localparam int TW     = 32;
  localparam int REFI   = 1560;
  localparam int RP     = 6;
  localparam int RAS    = 15;
  localparam int RTP    = 4;
  localparam int WRM    = 5 + 4 + 6;
  localparam int RFC    = 44;
  localparam int BW     = 3;
  localparam int GAP    = (NB > RP) ? NB : RP;
  localparam int REFB0  = REFI - (NB - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    qryCmd = 2'd3;
  logic [BW-1:0] qryBank = '0;
  logic [TW-1:0] qryCycle = '0;
  logic          insValid = 1'b0;
  logic [BW-1:0] insBank = '0;
  logic [TW-1:0] insCycle = '0;
  logic [TW-1:0] earliest;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  refb_guard dut_i (
    .clk (clk), .rst_n (rst_n), .qryCmd (qryCmd), .qryBank (qryBank),
    .qryCycle (qryCycle), .insValid (insValid), .insBank (insBank),
    .insCycle (insCycle), .earliest (earliest)
  );

  function automatic int refbOf(int b); return REFB0 + b; endfunction
  function automatic int preOf(int b);  return REFB0 + b - GAP; endfunction

  task automatic check(string req, logic [TW-1:0] got, int exp);
    checks++;
    if (got !== TW'(exp)) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic ask(int cmd, int bank, int cyc, output logic [TW-1:0] got);
    @(negedge clk);
    qryCmd = 2'(cmd); qryBank = BW'(bank); qryCycle = TW'(cyc);
    #1 got = earliest;
  endtask

  task automatic resetTest();
    logic [TW-1:0] g;
    ask(3, 0, 0, g);    check("R5 reset pre", g, 0);
    ask(0, 0, 100, g);  check("R1 reset act early", g, 100);
    ask(0, 5, 10, g);   check("R7 no bound before refresh", g, 10);
  endtask

  task automatic actTest();
    logic [TW-1:0] g;
    ask(0, 3, preOf(3) - RAS - 1, g); check("R2 act below", g, preOf(3) - RAS - 1);
    ask(0, 3, preOf(3) - RAS, g);     check("R2 act at", g, refbOf(3) + RFC);
    ask(0, 0, preOf(0) - RAS, g);     check("R1 bank0 stagger", g, refbOf(0) + RFC);
  endtask

  task automatic rdTest();
    logic [TW-1:0] g;
    ask(1, 0, preOf(0) - RTP - 1, g); check("R3 rd below", g, preOf(0) - RTP - 1);
    ask(1, 0, preOf(0) - RTP, g);     check("R3 rd at", g, refbOf(0) + RFC);
  endtask

  task automatic wrTest();
    logic [TW-1:0] g;
    ask(2, 7, preOf(7) - WRM - 1, g); check("R4 wr below", g, preOf(7) - WRM - 1);
    ask(2, 7, preOf(7) - WRM, g);     check("R4 wr at", g, refbOf(7) + RFC);
  endtask

  task automatic preTest();
    logic [TW-1:0] g;
    ask(3, 2, preOf(2) + 3, g); check("R5 pre near deadline", g, preOf(2) + 3);
  endtask

  task automatic lateTest();
    logic [TW-1:0] g;
    ask(0, 1, 5000, g); check("R8 late act", g, 5000);
    ask(2, 4, 4000, g); check("R8 late wr", g, 4000);
  endtask

  task automatic insertTest();
    logic [TW-1:0] g;
    int s;
    s = refbOf(2);
    @(negedge clk);
    insValid = 1'b1; insBank = 3'd2; insCycle = TW'(s);
    qryCmd = 2'd1; qryBank = 3'd2; qryCycle = TW'(preOf(2) - RTP + 2);
    #1 check("R6 same cycle old deadline", earliest, refbOf(2) + RFC);
    @(negedge clk);
    insValid = 1'b0;
    #1 check("R6 next cycle new deadline", earliest, preOf(2) - RTP + 2);
    ask(0, 2, s + 1, g);                   check("R7 act recovery", g, s + RFC);
    ask(0, 2, preOf(2) + REFI - RAS - 1, g); check("R6 act below new", g, preOf(2) + REFI - RAS - 1);
    ask(0, 2, preOf(2) + REFI - RAS, g);   check("R6 act at new", g, refbOf(2) + REFI + RFC);
    ask(0, 3, preOf(3) - RAS, g);          check("R6 neighbour unchanged", g, refbOf(3) + RFC);
    ask(3, 2, s + 1, g);                   check("R5 pre after refresh", g, s + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    resetTest();
    actTest();
    rdTest();
    wrTest();
    preTest();
    lateTest();
    insertTest();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule